// File: doc/BRIEF.md
# XTS Tweak Sequencer

This block produces the run of tweak values that an XTS data unit consumes, one block after another. An outside cipher encrypts the sector number and hands the result in as the seed. Software or a datapath controller then pulses the advance strobe once per data block. On each pulse the block presents the tweak that is current at that moment on a registered output. It then multiplies its internal tweak by the field element x, ready for the next block.

Three field arrangements are available, chosen when the seed is loaded. The standard 128-bit field uses reduction polynomial x^128 + x^7 + x^2 + x + 1. A single-lane 64-bit field uses polynomial x^64 + x^4 + x^3 + x + 1. A paired 64-bit arrangement packs two consecutive 64-bit tweaks into one 128-bit word and steps both lanes by x^2 per advance, so a wide datapath gets two narrow blocks' tweaks at once. Element bits are little-endian: bit 0 of a word is the coefficient of x^0.

Top module: `xts_tweak_seq`

## Requirements
- R1: While rst is high and in the first cycle after it, tweak_o is all zeros. The field mode after reset is the 128-bit field.
- R2: A load pulse captures seed_i and mode_i into the internal tweak state. It leaves tweak_o unchanged. The seed is first output on the cycle after the first advance that follows.
- R3: Mode codes 2'b00 and 2'b11 select the 128-bit field. In that field each accepted advance outputs the current tweak T, then replaces T with {T[126:0],0}. If T[127] was 1, 0x87 is XORed into bits 7:0. Block i is therefore paired with seed times x^i.
- R4: In the 128-bit field, bit 63 of the tweak moves into bit 64 on an advance, so the two 64-bit halves form one shifted element.
- R5: Mode code 2'b01 selects the single 64-bit field. Load keeps seed_i[63:0] and clears bits 127:64. Each advance outputs T, then shifts the low 64 bits left by one and XORs 0x1B into bits 7:0 when the bit shifted out was 1. Bits 127:64 stay zero.
- R6: Mode code 2'b10 selects the paired 64-bit arrangement. A load with seed S sets the low lane (bits 63:0) to S and the high lane to S·x in the 64-bit field. Each advance outputs both lanes. It then shifts each lane left by two and XORs into its bits 7:0 a value picked by the two bits shifted out, upper bit first: 00 gives 0x00, 01 gives 0x1B, 10 gives 0x36, 11 gives 0x2D.
- R7: An advance in the same cycle as a load is ignored. The load takes effect, tweak_o does not change, and the next advance outputs the new seed.
- R8: Without an advance, tweak_o holds its value.
- R9: mode_i is used only at a load. A change of mode_i between loads does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture seed_i and mode_i as a new data unit |
| seed_i | input | 128 | Encrypted initial tweak |
| mode_i | input | 2 | Field mode: 00/11 128-bit, 01 single 64-bit, 10 paired 64-bit |
| adv_i | input | 1 | Advance strobe: output current tweak, then step |
| tweak_o | output | 128 | Registered tweak for the current block |

## Verification
A load is absorbed in one edge and shows nothing on tweak_o. An advance driven before a rising edge makes tweak_o show the pre-step tweak right after that edge. The bench drives each stimulus after a falling edge and compares tweak_o at the next falling edge, one register stage later. The reference model steps the paired lanes by applying the single-x doubling twice, instead of using the two-bit fold table. Directed seeds with only bit 127, only bit 63, or the top two lane bits set check the reduction constants against literal values.

// File: rtl/xts_tweak_pkg.sv
package xts_tweak_pkg;
  typedef enum logic [1:0] {
    FLD128     = 2'b00,
    FLD64      = 2'b01,
    FLD64X2    = 2'b10,
    FLD128_ALT = 2'b11
  } fld_mode_e;
endpackage

// File: rtl/xts_lane_dbl.sv
// Multiply a W-bit field element by x: shift left one, fold the carry.
module xts_lane_dbl #(
  parameter int         W   = 128,
  parameter logic [7:0] RED = 8'h87
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  logic [7:0] fold;
  assign fold = a[W-1] ? RED : 8'h00;
  assign y    = {a[W-2:0], 1'b0} ^ {{(W-8){1'b0}}, fold};
endmodule

// File: rtl/xts_lane_quad.sv
// Multiply a W-bit field element by x^2 with a two-bit fold lookup.
module xts_lane_quad #(
  parameter int         W   = 64,
  parameter logic [7:0] RED = 8'h1B
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  localparam logic [7:0] RED2 = {RED[6:0], 1'b0};
  logic [7:0] fold;
  always_comb begin
    case (a[W-1:W-2])
      2'b00:   fold = 8'h00;
      2'b01:   fold = RED;
      2'b10:   fold = RED2;
      default: fold = RED2 ^ RED;
    endcase
  end
  assign y = {a[W-3:0], 2'b00} ^ {{(W-8){1'b0}}, fold};
endmodule

// File: rtl/xts_tweak_seq.sv
module xts_tweak_seq #(
  parameter int         TW     = 128,
  parameter logic [7:0] RED_TW = 8'h87,
  parameter logic [7:0] RED_HW = 8'h1B
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] seed_i,
  input  logic [1:0]    mode_i,
  input  logic          adv_i,
  output logic [TW-1:0] tweak_o
);
  import xts_tweak_pkg::*;

  localparam int HW    = TW / 2;
  localparam int LANES = 2;

  fld_mode_e       mode_q;
  logic [TW-1:0]   state_q;
  logic [TW-1:0]   nxt_full;
  logic [HW-1:0]   nxt_half;
  logic [TW-1:0]   nxt_pair;
  logic [HW-1:0]   seed_x;
  logic [TW-1:0]   nxt_state;
  logic [TW-1:0]   load_state;
  logic            step;

  assign step = adv_i && !load_i;

  xts_lane_dbl #(.W(TW), .RED(RED_TW)) u_dbl_full (
    .a(state_q), .y(nxt_full));

  xts_lane_dbl #(.W(HW), .RED(RED_HW)) u_dbl_half (
    .a(state_q[HW-1:0]), .y(nxt_half));

  xts_lane_dbl #(.W(HW), .RED(RED_HW)) u_dbl_seed (
    .a(seed_i[HW-1:0]), .y(seed_x));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    xts_lane_quad #(.W(HW), .RED(RED_HW)) u_quad (
      .a(state_q[l*HW +: HW]), .y(nxt_pair[l*HW +: HW]));
  end

  always_comb begin
    case (mode_q)
      FLD64:   nxt_state = {{HW{1'b0}}, nxt_half};
      FLD64X2: nxt_state = nxt_pair;
      default: nxt_state = nxt_full;
    endcase
  end

  always_comb begin
    case (fld_mode_e'(mode_i))
      FLD64:   load_state = {{HW{1'b0}}, seed_i[HW-1:0]};
      FLD64X2: load_state = {seed_x, seed_i[HW-1:0]};
      default: load_state = seed_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= FLD128;
      state_q <= '0;
      tweak_o <= '0;
    end else if (load_i) begin
      mode_q  <= fld_mode_e'(mode_i);
      state_q <= load_state;
    end else if (step) begin
      tweak_o <= state_q;
      state_q <= nxt_state;
    end
  end

  logic is_wide;
  assign is_wide = (mode_q == FLD128) || (mode_q == FLD128_ALT);

  // R3: the bit shifted out of the top reappears in bit 0 via 0x87
  a_r3_top_fold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(step) && $past(is_wide))
      |-> state_q[0] == $past(state_q[TW-1]));

  // R4: carry between the two halves
  a_r4_half_carry: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(step) && $past(is_wide))
      |-> state_q[HW] == $past(state_q[HW-1]));

  // R5: single 64-bit field keeps the upper half clear
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (mode_q == FLD64) |-> state_q[TW-1:HW] == '0);

  // R6: paired load puts the seed's top lane bit into the high lane's bit 0
  a_r6_pair_seed: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(load_i) && mode_q == FLD64X2)
      |-> (state_q[HW] == $past(seed_i[HW-1])) && (state_q[HW-1:0] == $past(seed_i[HW-1:0])));

  // R7: advance alongside load leaves the output alone
  a_r7_load_wins: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(load_i && adv_i)) |-> $stable(tweak_o));

  // R8: no advance, no output change
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(adv_i)) |-> $stable(tweak_o));
endmodule

// File: tb/xts_tweak_seq_tb.sv
module xts_tweak_seq_tb;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         load_i;
  logic [127:0] seed_i;
  logic [1:0]   mode_i;
  logic         adv_i;
  logic [127:0] tweak_o;

  int n_chk = 0;
  int n_err = 0;

  logic [127:0] ref_st;
  logic [1:0]   ref_mode;
  logic [127:0] exp_out;

  always #(CLK_P/2) clk = ~clk;

  xts_tweak_seq u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .seed_i(seed_i),
    .mode_i(mode_i), .adv_i(adv_i), .tweak_o(tweak_o));

  function automatic logic [127:0] m128(input logic [127:0] v);
    return {v[126:0], 1'b0} ^ (v[127] ? 128'h87 : 128'h0);
  endfunction

  function automatic logic [63:0] m64(input logic [63:0] v);
    return {v[62:0], 1'b0} ^ (v[63] ? 64'h1B : 64'h0);
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: tweak_o=%h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle, update the model, compare at the next falling edge.
  task automatic cyc(input logic l, input logic a, input logic [127:0] s,
                     input logic [1:0] m, input string tag);
    load_i = l; adv_i = a; seed_i = s; mode_i = m;
    @(negedge clk);
    if (l) begin
      ref_mode = m;
      case (m)
        2'b01:   ref_st = {64'h0, s[63:0]};
        2'b10:   ref_st = {m64(s[63:0]), s[63:0]};
        default: ref_st = s;
      endcase
    end else if (a) begin
      exp_out = ref_st;
      case (ref_mode)
        2'b01:   ref_st = {64'h0, m64(ref_st[63:0])};
        2'b10:   ref_st = {m64(m64(ref_st[127:64])), m64(m64(ref_st[63:0]))};
        default: ref_st = m128(ref_st);
      endcase
    end
    load_i = 1'b0; adv_i = 1'b0;
    chk(tag, tweak_o, exp_out);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] s;
    logic [1:0]   m;
    void'($urandom(32'd20240611));
    rst = 1'b1; load_i = 0; adv_i = 0; seed_i = '0; mode_i = 2'b00;
    ref_st = '0; ref_mode = 2'b00; exp_out = '0;
    repeat (3) @(negedge clk);
    chk("R1", tweak_o, 128'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", tweak_o, 128'h0);
    // R1: default mode is 128-bit; advance from zero state stays zero
    cyc(0, 1, '0, 2'b01, "R1");

    // R2: load leaves output alone; first advance shows seed
    s = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C};
    cyc(1, 0, s, 2'b00, "R2");
    chk("R2", tweak_o, 128'h0);
    cyc(0, 1, '0, 2'b00, "R2");
    chk("R2", tweak_o, s);

    // R3: top bit folds as 0x87 after two advances
    cyc(1, 0, 128'h8000_0000_0000_0000_0000_0000_0000_0000, 2'b11, "R3");
    cyc(0, 1, '0, 2'b00, "R3");
    cyc(0, 1, '0, 2'b00, "R3");
    chk("R3", tweak_o, 128'h87);

    // R4: bit 63 crosses into bit 64
    cyc(1, 0, 128'h0000_0000_0000_0000_8000_0000_0000_0000, 2'b00, "R4");
    cyc(0, 1, '0, 2'b00, "R4");
    cyc(0, 1, '0, 2'b00, "R4");
    chk("R4", tweak_o, 128'h0000_0000_0000_0001_0000_0000_0000_0000);

    // R5: 64-bit fold and cleared upper half
    cyc(1, 0, 128'hFFFF_FFFF_FFFF_FFFF_8000_0000_0000_0000, 2'b01, "R5");
    cyc(0, 1, '0, 2'b01, "R5");
    chk("R5", tweak_o, 128'h0000_0000_0000_0000_8000_0000_0000_0000);
    cyc(0, 1, '0, 2'b01, "R5");
    chk("R5", tweak_o, 128'h1B);

    // R6: paired load and the 11 fold value 0x2D
    cyc(1, 0, {64'h0, 64'hC000_0000_0000_0000}, 2'b10, "R6");
    cyc(0, 1, '0, 2'b10, "R6");
    chk("R6", tweak_o, {64'h8000_0000_0000_001B, 64'hC000_0000_0000_0000});
    cyc(0, 1, '0, 2'b10, "R6");
    chk("R6", tweak_o[63:0], 64'h2D);

    // R7: advance together with load is dropped
    s = {$urandom, $urandom, $urandom, $urandom};
    exp_out = tweak_o;
    cyc(1, 1, s, 2'b00, "R7");
    cyc(0, 1, '0, 2'b00, "R7");
    chk("R7", tweak_o, s);

    // R8: idle cycles hold the output
    for (int i = 0; i < 4; i++) cyc(0, 0, {$urandom, $urandom, $urandom, $urandom}, 2'(i), "R8");

    // R9: mode_i wiggles between loads without effect
    cyc(1, 0, {$urandom, $urandom, $urandom, $urandom}, 2'b10, "R9");
    for (int i = 0; i < 6; i++) cyc(0, 1, '0, 2'($urandom), "R9");

    // Random data units in every mode
    for (int u = 0; u < 60; u++) begin
      s = {$urandom, $urandom, $urandom, $urandom};
      m = 2'($urandom);
      cyc(1, 0, s, m, "R2");
      for (int k = 0; k < 3 + int'($urandom % 8); k++)
        cyc(0, ($urandom % 5) != 0, '0, 2'($urandom), tag_of(m));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule